// File: doc/BRIEF.md
# UART Byte Queues with Control and Status Registers

This block sits between a processor's register port and the bit-level serializer and deserializer of a UART. It holds two byte queues of 256 entries each. One carries bytes written by software out toward the serializer. The other carries bytes delivered by the deserializer in toward software.

Software sees four word registers: control, status, transmit data and receive data. The control register has a global enable and a clear bit for each queue. A clear bit empties its queue and then drops back to 0 by itself, so software can poll it. The status register gives the receive occupancy, a receive-full flag and a transmit-full flag. The occupancy field is eight bits wide, so it reads 0 when the receive queue holds 256 bytes. Software therefore tests "count non-zero OR receive-full" to learn whether a byte is waiting.

On the line side, the deserializer offers a byte with a one-cycle strobe. The serializer takes bytes over a valid/ready handshake.

Top module: `uart_fifo_regs`

## Requirements
- R1: After the synchronous active-high reset, control reads 0, status reads 0 and `tx_valid` is 0.
- R2: `reg_addr` selects control (0), status (1), transmit data (2) or receive data (3). A read's data appears on `reg_rdata` in the cycle after `reg_rd`. Control bit 0 is the enable and reads back as written.
- R3: Writing 1 to control bit 1 empties the receive queue, and writing 1 to control bit 2 empties the transmit queue together with its output byte. A read issued in the cycle right after the write shows the bit as 1. It reads 0 from then on, and the queue is empty within 2 cycles of the write.
- R4: Status bits [7:0] hold the receive occupancy modulo 256, bit 8 is receive-full and bit 24 is transmit-full. All other bits read 0.
- R5: A write to transmit data queues its low 8 bits. Bytes leave on `tx_data` in write order. Once `tx_valid` is high, `tx_valid` and `tx_data` hold until a cycle with `tx_ready` high.
- R6: A cycle with `rx_valid` high queues `rx_data`. A read of receive data removes the oldest byte and returns it in bits [7:0], with the upper bits 0.
- R7: Each queue holds 256 bytes. With 256 received bytes, status reads count 0 with bit 8 set.
- R8: A transmit write while transmit-full is ignored, and so is a received byte while receive-full. A read of an empty receive queue returns 0 and changes nothing.
- R9: While the enable is 0, received bytes are dropped and no new byte is presented to the serializer. Transmit writes are still queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | BUS_W | Write data |
| reg_rdata | output | BUS_W | Read data, valid the cycle after `reg_rd` |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_data | input | DW | Deserializer byte |
| tx_valid | output | 1 | Byte offered to the serializer |
| tx_data | output | DW | Byte to the serializer |
| tx_ready | input | 1 | Serializer takes the byte this cycle |

## Verification
The bench fills the receive queue to exactly 256 bytes and expects a count of 0 with the full flag set. A design whose count field were wider or saturated would show 256 or 255 instead. It offers a 257th byte and writes a 257th transmit byte, and it reads the empty queue. A design that overwrote old data or moved a pointer on these would return a corrupted byte sequence or a non-zero value. It reads the control register in the very cycle after a clear write and again one cycle later. A design whose clear bit stuck, or never became visible, would return the wrong pattern, and a design whose clear missed the output byte would send a stale byte. Random traffic with a stalling serializer checks ordering and the hold of `tx_data` under back-pressure.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TXD  = 2'd2,
    REG_RXD  = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_RXCLR_BIT  = 1;
  localparam int CTRL_TXCLR_BIT  = 2;
  localparam int STAT_RXFULL_BIT = 8;
  localparam int STAT_TXFULL_BIT = 24;
  localparam int STAT_CNT_W      = 8;
endpackage

// File: rtl/uart_sync_fifo.sv
module uart_sync_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (count == (AW+1)'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop && !clr) begin
      rdata <= pop_ok ? mem[rptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_stage.sv
module uart_tx_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          enable,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_pop,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready
);
  logic load;

  assign load     = enable && !fifo_empty && !clr && (!tx_valid || tx_ready);
  assign fifo_pop = load;
  assign tx_data  = fifo_rdata;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_valid <= 1'b0;
    end else if (load) begin
      tx_valid <= 1'b1;
    end else if (tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_fifo_regs.sv
module uart_fifo_regs
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_data,
  output logic             tx_valid,
  output logic [DW-1:0]    tx_data,
  input  logic             tx_ready
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CNT_SHOW = (AW < STAT_CNT_W) ? AW : STAT_CNT_W;

  logic          fifo_en;
  logic          rx_clr_pend, tx_clr_pend;
  logic [1:0]    rd_sel_q;
  logic [BUS_W-1:0] reg_q;
  logic [BUS_W-1:0] stat_word, ctrl_word;

  logic [AW:0]   rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic [DW-1:0] rx_rdata, tx_rdata;
  logic          rx_push, rx_pop, tx_push, tx_pop;
  logic          wr_ctrl;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign tx_push = reg_wr && (reg_addr == REG_TXD);
  assign rx_pop  = reg_rd && (reg_addr == REG_RXD);
  assign rx_push = rx_valid && fifo_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_en     <= 1'b0;
      rx_clr_pend <= 1'b0;
      tx_clr_pend <= 1'b0;
    end else begin
      rx_clr_pend <= 1'b0;
      tx_clr_pend <= 1'b0;
      if (wr_ctrl) begin
        fifo_en     <= reg_wdata[CTRL_EN_BIT];
        rx_clr_pend <= reg_wdata[CTRL_RXCLR_BIT];
        tx_clr_pend <= reg_wdata[CTRL_TXCLR_BIT];
      end
    end
  end

  uart_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (rx_clr_pend),
    .push  (rx_push),
    .wdata (rx_data),
    .pop   (rx_pop),
    .rdata (rx_rdata),
    .count (rx_cnt),
    .full  (rx_full),
    .empty (rx_empty)
  );

  uart_sync_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (tx_clr_pend),
    .push  (tx_push),
    .wdata (reg_wdata[DW-1:0]),
    .pop   (tx_pop),
    .rdata (tx_rdata),
    .count (tx_cnt),
    .full  (tx_full),
    .empty (tx_empty)
  );

  uart_tx_stage #(.DW(DW)) u_tx_stage (
    .clk        (clk),
    .rst        (rst),
    .clr        (tx_clr_pend),
    .enable     (fifo_en),
    .fifo_empty (tx_empty),
    .fifo_rdata (tx_rdata),
    .fifo_pop   (tx_pop),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready)
  );

  always_comb begin
    ctrl_word = '0;
    ctrl_word[CTRL_EN_BIT]    = fifo_en;
    ctrl_word[CTRL_RXCLR_BIT] = rx_clr_pend;
    ctrl_word[CTRL_TXCLR_BIT] = tx_clr_pend;
    stat_word = '0;
    stat_word[CNT_SHOW-1:0]    = rx_cnt[CNT_SHOW-1:0];
    stat_word[STAT_RXFULL_BIT] = rx_full;
    stat_word[STAT_TXFULL_BIT] = tx_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel_q <= REG_CTRL;
      reg_q    <= '0;
    end else if (reg_rd) begin
      rd_sel_q <= reg_addr;
      case (reg_addr)
        REG_CTRL: reg_q <= ctrl_word;
        REG_STAT: reg_q <= stat_word;
        default:  reg_q <= '0;
      endcase
    end
  end

  assign reg_rdata = (rd_sel_q == REG_RXD) ? {{(BUS_W-DW){1'b0}}, rx_rdata} : reg_q;
endmodule

// File: rtl/uart_fifo_regs_chk.sv
module uart_fifo_regs_chk #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    fifo_en,
  input logic                    rx_clr_pend,
  input logic                    tx_clr_pend,
  input logic [$clog2(DEPTH):0]  rx_cnt,
  input logic [$clog2(DEPTH):0]  tx_cnt,
  input logic                    tx_valid,
  input logic                    tx_ready,
  input logic [DW-1:0]           tx_data
);
  localparam int AW = $clog2(DEPTH);

  // R3: clear bits drop by themselves after one cycle
  assert_rx_clr_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
    rx_clr_pend |=> !rx_clr_pend);
  assert_tx_clr_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
    tx_clr_pend |=> !tx_clr_pend);

  // R3: queue is empty once the clear has acted
  assert_rx_clr_empties_R3: assert property (@(posedge clk) disable iff (rst)
    rx_clr_pend |=> (rx_cnt == '0));
  assert_tx_clr_empties_R3: assert property (@(posedge clk) disable iff (rst)
    tx_clr_pend |=> (tx_cnt == '0) && !tx_valid);

  // R5: offered byte holds under back-pressure
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready && !tx_clr_pend |=> tx_valid && $stable(tx_data));

  // R7: occupancy never passes the depth
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt <= (AW+1)'(DEPTH)) && (tx_cnt <= (AW+1)'(DEPTH)));

  // R9: disabled block takes no received byte
  assert_rx_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !fifo_en |=> rx_cnt <= $past(rx_cnt));
endmodule

bind uart_fifo_regs uart_fifo_regs_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_en     (fifo_en),
  .rx_clr_pend (rx_clr_pend),
  .tx_clr_pend (tx_clr_pend),
  .rx_cnt      (rx_cnt),
  .tx_cnt      (tx_cnt),
  .tx_valid    (tx_valid),
  .tx_ready    (tx_ready),
  .tx_data     (tx_data)
);

// File: tb/uart_fifo_regs_tb.sv
module uart_fifo_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit en_m = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fifo_regs u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(input int rxn, input int txn);
    logic [31:0] v;
    v = 32'(rxn % 256);
    if (rxn == DEPTH) v[8] = 1'b1;
    if (txn == DEPTH) v[24] = 1'b1;
    return v;
  endfunction

  task automatic cycle();
    logic xfer;
    logic [7:0] d;
    logic [7:0] e;
    xfer = tx_valid && tx_ready;
    d = tx_data;
    @(posedge clk);
    @(negedge clk);
    if (xfer) begin
      if (tx_q.size() == 0) chk(1'b0, "R5 unexpected byte", d, 0);
      else begin
        e = tx_q.pop_front();
        chk(d == e, "R5 tx order", d, e);
      end
    end
    reg_wr = 0; reg_rd = 0; rx_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (a == 2'd0) begin
      en_m = d[0];
      if (d[1]) rx_q.delete();
      if (d[2]) tx_q.delete();
    end
    if (a == 2'd2 && tx_q.size() < DEPTH) tx_q.push_back(d[7:0]);
    cycle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    cycle();
    v = reg_rdata;
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_valid = 1; rx_data = b;
    if (en_m && rx_q.size() < DEPTH) rx_q.push_back(b);
    cycle();
  endtask

  task automatic rx_read_check(input string req);
    logic [31:0] v;
    logic [31:0] e;
    e = (rx_q.size() > 0) ? {24'd0, rx_q.pop_front()} : 32'd0;
    rd(2'd3, v);
    chk(v == e, req, v, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    rx_valid = 0; rx_data = 0; tx_ready = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1 reset state
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 status", v, 0);

    // R2 enable readback
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk(v == 32'h1, "R2 ctrl enable", v, 1);

    // R4 / R6 small receive traffic
    rx_push(8'hA1); rx_push(8'hB2); rx_push(8'hC3);
    rd(2'd1, v); chk(v == stat_exp(3, 0), "R4 status count", v, stat_exp(3, 0));
    rx_read_check("R6 rx oldest");

    // random mixed traffic (R5, R6)
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] e;
      bit do_rd;
      op = int'($urandom % 4);
      tx_ready = 1'($urandom);
      do_rd = 0;
      e = 0;
      if (op == 0 && tx_q.size() < 200) begin
        reg_wr = 1; reg_addr = 2'd2; reg_wdata = $urandom;
        tx_q.push_back(reg_wdata[7:0]);
      end else if (op == 1) begin
        reg_rd = 1; reg_addr = 2'd3; do_rd = 1;
        e = (rx_q.size() > 0) ? {24'd0, rx_q.pop_front()} : 32'd0;
      end
      if ($urandom % 2 == 0 && rx_q.size() < 250) begin
        rx_valid = 1; rx_data = 8'($urandom);
        rx_q.push_back(rx_data);
      end
      cycle();
      if (do_rd) chk(reg_rdata == e, "R6 random rx read", reg_rdata, e);
    end
    tx_ready = 1;
    idle(300);
    chk(tx_q.size() == 0, "R5 tx drained", tx_q.size(), 0);
    while (rx_q.size() > 0) rx_read_check("R6 rx drain");

    // R7 / R8 receive full
    for (int i = 0; i < DEPTH + 1; i++) rx_push(8'(i * 7 + 3));
    rd(2'd1, v); chk(v == 32'h100, "R7 count wraps with full flag", v, 32'h100);
    for (int i = 0; i < DEPTH; i++) rx_read_check("R8 rx full sequence");
    rx_read_check("R8 empty read returns 0");
    rd(2'd1, v); chk(v == 0, "R8 empty status", v, 0);

    // R3 receive clear
    for (int i = 0; i < 5; i++) rx_push(8'(i + 1));
    wr(2'd0, 32'h3);
    rd(2'd0, v); chk(v == 32'h3, "R3 rx clear visible", v, 3);
    rd(2'd0, v); chk(v == 32'h1, "R3 rx clear self-cleared", v, 1);
    rd(2'd1, v); chk(v == 0, "R3 rx emptied", v, 0);

    // R9 disabled
    wr(2'd0, 32'h0);
    rx_push(8'h55);
    rd(2'd1, v); chk(v == 0, "R9 rx dropped when disabled", v, 0);
    wr(2'd2, 32'h0000_0011);
    idle(5);
    chk(tx_valid == 0, "R9 no tx when disabled", tx_valid, 0);

    // R8 transmit full
    for (int i = 0; i < DEPTH; i++) wr(2'd2, 32'(i + 32'h40));
    rd(2'd1, v); chk(v == 32'h0100_0000, "R8 tx full flag", v, 32'h0100_0000);
    chk(tx_q.size() == DEPTH, "R8 model depth", tx_q.size(), DEPTH);

    // R5 hold under back-pressure
    tx_ready = 0;
    wr(2'd0, 32'h1);
    idle(3);
    chk(tx_valid == 1, "R5 valid offered", tx_valid, 1);
    chk(tx_data == tx_q[0], "R5 first byte", tx_data, tx_q[0]);
    idle(3);
    chk(tx_valid == 1 && tx_data == tx_q[0], "R5 held under stall", tx_data, tx_q[0]);
    tx_ready = 1;
    idle(300);
    chk(tx_q.size() == 0, "R8 exactly depth bytes sent", tx_q.size(), 0);

    // R3 transmit clear
    tx_ready = 0;
    wr(2'd0, 32'h0);
    for (int i = 0; i < 4; i++) wr(2'd2, 32'(i + 32'h90));
    wr(2'd0, 32'h4);
    rd(2'd0, v); chk(v == 32'h4, "R3 tx clear visible", v, 4);
    rd(2'd0, v); chk(v == 32'h0, "R3 tx clear self-cleared", v, 0);
    wr(2'd0, 32'h1);
    tx_ready = 1;
    idle(10);
    chk(tx_valid == 0, "R3 tx emptied", tx_valid, 0);
    rd(2'd1, v); chk(v == 0, "R3 status after clears", v, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule